// File: doc/BRIEF.md
# Flash Command Decoder and Operation Sequencer

This block sits between a byte-wide write/read port and a behavioural nonvolatile byte array. Each byte written to it is taken as a command or as the second cycle of a two-cycle command. The block decodes these writes into a small set of operations: return to array reads, byte program, sector erase, status read, status clear and identifier read. A program or erase starts a timed busy period. When that period ends, the array is updated and the result is recorded in a status register.

What a read returns depends on the current read mode: array bytes, the status register, or identifier bytes. While an operation runs, every read returns status. Protection is not decided inside the block. A single permit input, sampled on the data or confirm cycle, says whether the operation may touch the array.

The array is divided into equal main sectors, plus a top region of main-sector size. That top region is split into four smaller sectors of one half, one quarter, one eighth and one eighth of a main sector. No command erases the whole array.

Top module: `fcui_top`

## Requirements
- R1: After reset the array holds 0xFF in every byte, `ready` is 1, reads return array data, and the status register reads 0x80.
- R2: Writing 0xFF in the idle state selects array reads, so `rd_data` returns the byte at `rd_addr`.
- R3: Writing 0x40 or 0x10 and then a data byte at an address programs that byte to old AND data, after a busy period of PROG_CYC clocks.
- R4: If the program data has a 1 where the stored byte has a 0, status bit 4 (program error) is set. The byte still becomes old AND data.
- R5: Writing 0x20 and then 0xD0 at any address inside a sector sets every byte of that sector to 0xFF, after ERASE_CYC busy clocks, and leaves all other sectors unchanged. The sector map is as follows. Main sectors are aligned blocks of 2^MAIN_AW bytes below the top region. The top region covers the last 2^MAIN_AW bytes and is split, in rising address order, into parts of 1/2, 1/4, 1/8 and 1/8 of that size.
- R6: If the cycle after 0x20 carries any byte other than 0xD0, status bit 5 (erase error) is set, no busy period starts, and the array is unchanged.
- R7: Writing 0x70 selects status reads, and a program or erase start also selects status reads. Status bit 7 is ready, bit 5 is erase error, bit 4 is program error, bit 1 is protection error, and all other bits are 0. While busy, reads return status whatever the mode.
- R8: Writing 0x50 clears status bits 5, 4 and 1, and leaves the read mode unchanged.
- R9: Writing 0x90 selects identifier reads. Address 0 returns MFR_CODE (default 0xA5), address 1 returns DEV_CODE (default 0x3C), and every other address returns 0x00.
- R10: A program data cycle or an erase confirm cycle with `wr_permit` low sets status bit 1, starts no busy period and leaves the array unchanged.
- R11: Writes during a busy period are ignored. A first-cycle byte that is not a known command changes neither the read mode nor the array.
- R12: `ready` is low for exactly PROG_CYC clocks after a program start and for exactly ERASE_CYC clocks after an erase start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per written byte |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data or command byte |
| wr_permit | input | 1 | Operation permitted, sampled on the program data or erase confirm cycle |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Read data: array byte, status or identifier |
| ready | output | 1 | 1 when no automated operation runs |

## Verification
The assertions assume that every write strobe lasts one clock and that `wr_permit` is stable while the strobe is high. They also assume the busy-length parameters are at least 1. The busy-length assertion compares the run of low `ready` cycles against the parameter that belongs to the operation kind recorded at the start.

The stimulus drives every write on a falling edge and holds it for exactly one rising edge. It issues commands during busy periods only in the dedicated test of R11. This keeps the rejection, clear and completion properties inside the conditions they assume.

// File: rtl/fcui_pkg.sv
package fcui_pkg;

  typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_IDENT} rd_mode_e;
  typedef enum logic [1:0] {CS_IDLE, CS_PROG, CS_ERASE} cmd_state_e;

  localparam logic [7:0] CMD_READ   = 8'hFF;
  localparam logic [7:0] CMD_PROG_A = 8'h40;
  localparam logic [7:0] CMD_PROG_B = 8'h10;
  localparam logic [7:0] CMD_ERASE  = 8'h20;
  localparam logic [7:0] CMD_CONF   = 8'hD0;
  localparam logic [7:0] CMD_STAT   = 8'h70;
  localparam logic [7:0] CMD_CLR    = 8'h50;
  localparam logic [7:0] CMD_IDENT  = 8'h90;

  // Sector index of a byte address: aligned main sectors first, then the
  // top main-sized region split as 1/2, 1/4, 1/8, 1/8 in rising order.
  function automatic int unsigned sector_of(int unsigned addr, int unsigned aw,
                                            int unsigned mw);
    int unsigned msz;
    int unsigned tbase;
    int unsigned off;
    int unsigned nmain;
    msz   = 32'd1 << mw;
    tbase = (32'd1 << aw) - msz;
    nmain = tbase >> mw;
    if (addr < tbase) return addr >> mw;
    off = addr - tbase;
    if (off < msz / 2)     return nmain;
    if (off < msz * 3 / 4) return nmain + 1;
    if (off < msz * 7 / 8) return nmain + 2;
    return nmain + 3;
  endfunction

  // Program result: cells can only go from 1 to 0.
  function automatic logic [7:0] prog_result(logic [7:0] old, logic [7:0] din);
    return old & din;
  endfunction

  // True when the data asks for a 0 -> 1 transition.
  function automatic logic prog_fails(logic [7:0] old, logic [7:0] din);
    return (din & ~old) != 8'h00;
  endfunction

endpackage

// File: rtl/fcui_array.sv
module fcui_array #(
  parameter int AW      = 8,
  parameter int MAIN_AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit_prog,
  input  logic          commit_erase,
  input  logic [AW-1:0] op_addr,
  input  logic [7:0]    op_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_byte,
  output logic [7:0]    op_byte
);
  import fcui_pkg::*;

  localparam int DEPTH = 1 << AW;

  logic [7:0]  mem [DEPTH];
  logic [31:0] tgt_sector;

  assign tgt_sector = sector_of(32'(op_addr), AW, MAIN_AW);
  assign rd_byte    = mem[rd_addr];
  assign op_byte    = mem[op_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit_prog) begin
      mem[op_addr] <= prog_result(mem[op_addr], op_data);
    end else if (commit_erase) begin
      for (int i = 0; i < DEPTH; i++)
        if (sector_of(i, AW, MAIN_AW) == tgt_sector) mem[i] <= 8'hFF;
    end
  end

endmodule

// File: rtl/fcui_timer.sv
module fcui_timer #(
  parameter int PROG_CYC  = 5,
  parameter int ERASE_CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_prog,
  input  logic start_erase,
  output logic busy,
  output logic done
);
  localparam int LONGEST = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW      = $clog2(LONGEST + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start_prog) begin
      busy <= 1'b1;
      cnt  <= CW'(PROG_CYC - 1);
    end else if (start_erase) begin
      busy <= 1'b1;
      cnt  <= CW'(ERASE_CYC - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);

endmodule

// File: rtl/fcui_seq.sv
module fcui_seq #(
  parameter int AW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [7:0]         wr_data,
  input  logic               wr_permit,
  input  logic               busy,
  input  logic               done,
  input  logic [7:0]         op_byte,
  output logic               start_prog,
  output logic               start_erase,
  output logic               commit_prog,
  output logic               commit_erase,
  output logic               ev_prot,
  output logic               ev_seqerr,
  output logic               ev_clear,
  output logic [AW-1:0]      op_addr,
  output logic [7:0]         op_data,
  output logic [7:0]         status,
  output fcui_pkg::rd_mode_e rd_mode
);
  import fcui_pkg::*;

  cmd_state_e state;
  logic       op_erase;
  logic       err_erase, err_prog, err_lock;
  logic       accept;

  assign accept = wr_en && !busy;

  always_comb begin
    start_prog  = 1'b0;
    start_erase = 1'b0;
    ev_prot     = 1'b0;
    ev_seqerr   = 1'b0;
    ev_clear    = 1'b0;
    if (accept) begin
      case (state)
        CS_PROG: begin
          if (wr_permit) start_prog = 1'b1;
          else           ev_prot    = 1'b1;
        end
        CS_ERASE: begin
          if (wr_data != CMD_CONF) ev_seqerr   = 1'b1;
          else if (wr_permit)      start_erase = 1'b1;
          else                     ev_prot     = 1'b1;
        end
        default: ev_clear = (wr_data == CMD_CLR);
      endcase
    end
  end

  assign commit_prog  = done && !op_erase;
  assign commit_erase = done && op_erase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= CS_IDLE;
      rd_mode  <= RM_ARRAY;
      op_erase <= 1'b0;
      op_addr  <= '0;
      op_data  <= 8'hFF;
    end else if (accept) begin
      case (state)
        CS_PROG, CS_ERASE: begin
          state   <= CS_IDLE;
          rd_mode <= RM_STATUS;
          if (start_prog || start_erase) begin
            op_addr  <= wr_addr;
            op_data  <= wr_data;
            op_erase <= start_erase;
          end
        end
        default: begin
          case (wr_data)
            CMD_READ:               rd_mode <= RM_ARRAY;
            CMD_STAT:               rd_mode <= RM_STATUS;
            CMD_IDENT:              rd_mode <= RM_IDENT;
            CMD_PROG_A, CMD_PROG_B: state   <= CS_PROG;
            CMD_ERASE:              state   <= CS_ERASE;
            default:                ;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_erase <= 1'b0;
      err_prog  <= 1'b0;
      err_lock  <= 1'b0;
    end else begin
      if (ev_clear) begin
        err_erase <= 1'b0;
        err_prog  <= 1'b0;
        err_lock  <= 1'b0;
      end
      if (ev_prot)   err_lock  <= 1'b1;
      if (ev_seqerr) err_erase <= 1'b1;
      if (commit_prog && prog_fails(op_byte, op_data)) err_prog <= 1'b1;
    end
  end

  assign status = {~busy, 1'b0, err_erase, err_prog, 2'b00, err_lock, 1'b0};

endmodule

// File: rtl/fcui_top.sv
module fcui_top #(
  parameter int         AW        = 8,
  parameter int         MAIN_AW   = 5,
  parameter int         PROG_CYC  = 5,
  parameter int         ERASE_CYC = 12,
  parameter logic [7:0] MFR_CODE  = 8'hA5,
  parameter logic [7:0] DEV_CODE  = 8'h3C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          wr_permit,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          ready
);
  import fcui_pkg::*;

  // Named internal events, also observed by the bound checker.
  logic          ev_start_prog, ev_start_erase, ev_done;
  logic          ev_prot, ev_seqerr, ev_clear;
  logic          commit_prog, commit_erase, busy;
  logic [AW-1:0] op_addr;
  logic [7:0]    op_data, op_byte, rd_byte, status_q;
  logic [2:0]    err_flags;
  rd_mode_e      rd_mode;

  fcui_seq #(.AW(AW)) u_seq (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .wr_permit,
    .busy, .done(ev_done), .op_byte,
    .start_prog(ev_start_prog), .start_erase(ev_start_erase),
    .commit_prog, .commit_erase, .ev_prot, .ev_seqerr, .ev_clear,
    .op_addr, .op_data, .status(status_q), .rd_mode
  );

  fcui_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_timer (
    .clk, .rst_n, .start_prog(ev_start_prog), .start_erase(ev_start_erase),
    .busy, .done(ev_done)
  );

  fcui_array #(.AW(AW), .MAIN_AW(MAIN_AW)) u_array (
    .clk, .rst_n, .commit_prog, .commit_erase, .op_addr, .op_data,
    .rd_addr, .rd_byte, .op_byte
  );

  assign ready     = ~busy;
  assign err_flags = {status_q[5], status_q[4], status_q[1]};

  always_comb begin
    if (busy || rd_mode == RM_STATUS)  rd_data = status_q;
    else if (rd_mode == RM_IDENT) begin
      if (rd_addr == '0)              rd_data = MFR_CODE;
      else if (rd_addr == AW'(1))     rd_data = DEV_CODE;
      else                            rd_data = 8'h00;
    end else                          rd_data = rd_byte;
  end

endmodule

// File: rtl/fcui_chk.sv
module fcui_chk #(
  parameter int PROG_CYC  = 5,
  parameter int ERASE_CYC = 12
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_prog,
  input logic       start_erase,
  input logic       done,
  input logic       ready,
  input logic       prot,
  input logic       clear,
  input logic [2:0] err_flags
);
  int run_cnt;
  int want;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= 0;
      want    <= 0;
    end else if (start_prog) begin
      run_cnt <= 1;
      want    <= PROG_CYC;
    end else if (start_erase) begin
      run_cnt <= 1;
      want    <= ERASE_CYC;
    end else if (!ready) begin
      run_cnt <= run_cnt + 1;
    end
  end

  assert_busy_length_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_cnt == want));

  assert_done_releases_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ready);

  assert_no_start_when_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_prog || start_erase) |-> ready);

  assert_prot_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    prot |=> (ready && err_flags[0]));

  assert_clear_errors_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (err_flags == 3'b000));

  assert_single_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_prog, start_erase, prot}));

endmodule

bind fcui_top fcui_chk #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_prog(ev_start_prog),
  .start_erase(ev_start_erase), .done(ev_done), .ready(ready),
  .prot(ev_prot), .clear(ev_clear), .err_flags(err_flags)
);

// File: tb/fcui_top_tb.sv
module fcui_top_tb;
  localparam int DEPTH     = 256;
  localparam int MSZ       = 32;
  localparam int NMAIN     = (DEPTH - MSZ) / MSZ;
  localparam int NSEC      = NMAIN + 4;
  localparam int PROG_CYC  = 5;
  localparam int ERASE_CYC = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_permit = 1'b1;
  logic [7:0] wr_addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_addr = 8'h00;
  logic [7:0] rd_data;
  logic       ready;

  always #5 clk = ~clk;

  fcui_top u_dut (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .wr_permit,
    .rd_addr, .rd_data, .ready
  );

  int         total = 0;
  int         bad = 0;
  logic [7:0] model [DEPTH];

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic p);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_permit = p;
    @(negedge clk);
    wr_en = 1'b0; wr_permit = 1'b1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (ready !== 1'b1) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic cmp_all(input string tag);
    logic [7:0] d;
    for (int a = 0; a < DEPTH; a++) begin
      rd(8'(a), d);
      check(tag, d, model[a]);
    end
  endtask

  function automatic int sec_base(input int s);
    if (s < NMAIN) return s * MSZ;
    case (s - NMAIN)
      0:       return NMAIN * MSZ;
      1:       return NMAIN * MSZ + MSZ / 2;
      2:       return NMAIN * MSZ + (MSZ / 4) * 3;
      default: return NMAIN * MSZ + (MSZ / 8) * 7;
    endcase
  endfunction

  function automatic int sec_size(input int s);
    if (s < NMAIN) return MSZ;
    case (s - NMAIN)
      0:       return MSZ / 2;
      1:       return MSZ / 4;
      default: return MSZ / 8;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n;
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 ready", {7'd0, ready}, 8'h01);
    cmp_all("R1 erased");
    wr(8'h00, 8'h70, 1'b1);
    rd(8'h00, d); check("R1/R7 status", d, 8'h80);
    wr(8'h00, 8'hFF, 1'b1);
    rd(8'h04, d); check("R2 array mode", d, 8'hFF);

    // R3/R12: program every byte
    for (int a = 0; a < DEPTH; a++) begin
      logic [7:0] pat;
      pat = 8'(a) ^ 8'h5A;
      wr(8'(a), (a % 2 == 0) ? 8'h40 : 8'h10, 1'b1);
      wr(8'(a), pat, 1'b1);
      if (a == 0) begin
        rd(8'h00, d); check("R7 status while busy", d, 8'h00);
      end
      wait_ready(n);
      check("R12 program busy", 8'(n), 8'(PROG_CYC));
      model[a] = model[a] & pat;
    end
    rd(8'h00, d); check("R7 status after program", d, 8'h80);
    wr(8'h00, 8'hFF, 1'b1);
    cmp_all("R3 programmed");

    // R4: 0 -> 1 request
    wr(8'h05, 8'h40, 1'b1);
    wr(8'h05, ~model[5], 1'b1);
    wait_ready(n);
    model[5] = model[5] & ~model[5];
    rd(8'h05, d); check("R4 status", d, 8'h90);
    wr(8'h00, 8'hFF, 1'b1);
    rd(8'h05, d); check("R4 byte", d, model[5]);

    // R8: clear in array mode keeps array mode
    wr(8'h00, 8'h50, 1'b1);
    rd(8'h05, d); check("R8 mode kept", d, model[5]);
    wr(8'h00, 8'h70, 1'b1);
    rd(8'h00, d); check("R8 cleared", d, 8'h80);

    // R10: program and erase without permit
    wr(8'h07, 8'h40, 1'b1);
    wr(8'h07, 8'h00, 1'b0);
    check("R10 no busy prog", {7'd0, ready}, 8'h01);
    rd(8'h00, d); check("R10 status", d, 8'h82);
    wr(8'h00, 8'h20, 1'b1);
    wr(8'h00, 8'hD0, 1'b0);
    check("R10 no busy erase", {7'd0, ready}, 8'h01);
    wr(8'h00, 8'hFF, 1'b1);
    cmp_all("R10 array kept");
    wr(8'h00, 8'h50, 1'b1);

    // R6: bad confirm
    wr(8'h03, 8'h20, 1'b1);
    wr(8'h03, 8'h33, 1'b1);
    check("R6 no busy", {7'd0, ready}, 8'h01);
    rd(8'h00, d); check("R6 status", d, 8'hA0);
    wr(8'h00, 8'h50, 1'b1);
    rd(8'h00, d); check("R8 clear in status mode", d, 8'h80);
    wr(8'h00, 8'hFF, 1'b1);
    rd(8'h03, d); check("R6 byte kept", d, model[3]);

    // R11: unknown code, and writes while busy
    wr(8'h00, 8'h33, 1'b1);
    rd(8'h01, d); check("R11 unknown code", d, model[1]);
    wr(8'h0A, 8'h40, 1'b1);
    wr(8'h0A, 8'h00, 1'b1);
    model[10] = 8'h00;
    wr(8'h03, 8'h20, 1'b1);
    wr(8'h03, 8'hD0, 1'b1);
    wait_ready(n);
    wr(8'h03, 8'h70, 1'b1);
    rd(8'h00, d); check("R11 busy writes ignored", d, 8'h80);
    wr(8'h00, 8'hFF, 1'b1);
    cmp_all("R11 array");

    // R9: identifier reads
    wr(8'h00, 8'h90, 1'b1);
    rd(8'h00, d); check("R9 mfr", d, 8'hA5);
    rd(8'h01, d); check("R9 dev", d, 8'h3C);
    rd(8'h02, d); check("R9 other", d, 8'h00);
    rd(8'hFF, d); check("R9 top", d, 8'h00);
    wr(8'h00, 8'hFF, 1'b1);
    rd(8'h01, d); check("R2 back to array", d, model[1]);

    // R5/R12: erase each sector in turn
    for (int s = 0; s < NSEC; s++) begin
      int b;
      int z;
      b = sec_base(s);
      z = sec_size(s);
      wr(8'(b + z / 2), 8'h20, 1'b1);
      wr(8'(b + z / 2), 8'hD0, 1'b1);
      wait_ready(n);
      check("R12 erase busy", 8'(n), 8'(ERASE_CYC));
      rd(8'h00, d); check("R5 status", d, 8'h80);
      for (int i = b; i < b + z; i++) model[i] = 8'hFF;
      wr(8'h00, 8'hFF, 1'b1);
      cmp_all("R5 sector erase");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule